// File: doc/BRIEF.md
# Character Display Controller Host Register Interface

This block is the host-facing side of a character display controller. A host talks to it over an 8-bit data bus with a register-select input, a read/write input and an enable strobe. Register select 0 addresses the instruction side: writes there carry commands, and reads there return a status byte. Register select 1 addresses the data register, which stands between the host and an internal character memory.

The character memory has two banks. A 128-entry display bank and a 64-entry glyph bank share one 7-bit address counter, and a bank-select bit chooses between them. Host data writes are committed to the selected bank at the counter, and the counter then steps up or down. Host data reads return a byte that was fetched into the data register beforehand. Each read then triggers a refill from the next address. Every accepted operation holds a busy flag high for a fixed number of clocks, and writes and data reads that arrive while it is high are dropped. The data bus is split into an input, an output and an output enable, so the pad ring can build the bidirectional pin.

Top module: `chardisp_regif`

## Requirements
- R1: After reset the busy flag is 0, the address counter is 0, the display bank is selected, the step direction is increment and the data register holds 0x00, so a status read returns 0x00.
- R2: db_oe is 1 exactly while en = 1 and rw = 1, and 0 whenever en = 0.
- R3: A status read (rs = 0, rw = 1) puts the busy flag on bit 7 and the address counter on bits 6..0 of db_out. It changes no state.
- R4: Every accepted instruction write, data write or data read holds the busy flag at 1 for exactly BUSY_CYCLES clocks, starting on the clock that acts on the transaction.
- R5: While busy is 1, an instruction write, a data write or a data read taken from the bus is ignored. The address counter, the memory and the data register are left as they were.
- R6: Instruction byte 1aaaaaaa selects the display bank and loads aaaaaaa into the address counter. The data register is then refilled with the display byte at that address.
- R7: Instruction byte 01aaaaaa selects the glyph bank and loads 0aaaaaa into the address counter. The data register is then refilled with the glyph byte at that address.
- R8: Instruction byte 000001dx sets the step direction to d (1 = increment, 0 = decrement). Any other instruction byte changes no state apart from the busy flag.
- R9: A data write (rs = 1, rw = 0) stores the byte at the address counter in the selected bank, leaves that byte in the data register and steps the counter by one.
- R10: A data read (rs = 1, rw = 1) drives the data register onto db_out. The counter then steps by one and the data register is refilled from the new address.
- R11: The counter wraps modulo 128 in the display bank and modulo 64 in the glyph bank, in both directions.
- R12: A transaction acts on the values of rs, rw and db_in seen in the last clock that en was high. It takes effect after the falling edge of en has passed the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Host enable strobe; the transaction commits on its falling edge |
| rs | input | 1 | Register select: 0 = instruction/status, 1 = data register |
| rw | input | 1 | 1 = host read, 0 = host write |
| db_in | input | 8 | Data bus from the host |
| db_out | output | 8 | Data bus toward the host (status byte or data register) |
| db_oe | output | 1 | Output enable of the data bus pad |

## Verification
The assertions assume that the host holds en high for at least one full clock and low for at least one full clock, so that every strobe edge passes through the synchronizer. They also assume that rs, rw and db_in are valid during the clocks en is high. The bench always raises en for two clocks and keeps it low for at least one. It changes rs, rw and db_in only on falling clock edges. Between random operations it waits long enough for busy to clear, so the ordinary checks are not affected by a pending operation. A few directed sequences then deliberately strike during the busy window.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

   // {rs, rw} decode of a host transaction
   typedef enum logic [1:0] {
      OP_INSTR  = 2'b00,
      OP_STATUS = 2'b01,
      OP_DWRITE = 2'b10,
      OP_DREAD  = 2'b11
   } bus_op_e;

   typedef struct packed {
      logic       rs;
      logic       rw;
      logic [7:0] db;
   } bus_cmd_t;

   // One step of the 7-bit address counter; glyph bank keeps bit 6 clear
   function automatic logic [6:0] ac_step(input logic [6:0] ac,
                                          input logic up,
                                          input logic glyph);
      logic [6:0] nxt;
      nxt = up ? ac + 7'd1 : ac - 7'd1;
      if (glyph) nxt[6] = 1'b0;
      return nxt;
   endfunction

endpackage

// File: rtl/cdr_strobe_sync.sv
module cdr_strobe_sync
   import cdr_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  bus_cmd_t cmd_in,
   output logic     stb,
   output bus_cmd_t cmd
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cdr_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] en_pipe;
   bus_cmd_t          cmd_pipe [STAGES];
   logic              en_prev_q;
   bus_cmd_t          cap_q;

   // Strobe and bus fields travel through equal-length pipelines
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_pipe[s]  <= 1'b0;
            cmd_pipe[s] <= '0;
         end else if (s == 0) begin
            en_pipe[s]  <= en;
            cmd_pipe[s] <= cmd_in;
         end else begin
            en_pipe[s]  <= en_pipe[(s == 0) ? 0 : s-1];
            cmd_pipe[s] <= cmd_pipe[(s == 0) ? 0 : s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev_q <= 1'b0;
         cap_q     <= '0;
      end else begin
         en_prev_q <= en_pipe[STAGES-1];
         if (en_pipe[STAGES-1]) cap_q <= cmd_pipe[STAGES-1];
      end
   end

   assign stb = en_prev_q & ~en_pipe[STAGES-1];
   assign cmd = cap_q;

endmodule

// File: rtl/cdr_busy_timer.sv
module cdr_busy_timer #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);

   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("cdr_busy_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (start)     cnt_q <= CW'(CYCLES);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != 0);
   assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/cdr_ram.sv
module cdr_ram #(
   parameter int DEPTH = 128,
   parameter int DW    = 8
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DW-1:0]            rdata
);

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/chardisp_regif.sv
module chardisp_regif
   import cdr_pkg::*;
#(
   parameter int BUSY_CYCLES = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DD_DEPTH    = 128,
   parameter int CG_DEPTH    = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       rs,
   input  logic       rw,
   input  logic [7:0] db_in,
   output logic [7:0] db_out,
   output logic       db_oe
);

   localparam int AC_W  = $clog2(DD_DEPTH);
   localparam int CG_AW = $clog2(CG_DEPTH);

   if (AC_W != 7 || DD_DEPTH != (1 << AC_W)) begin : g_bad_dd
      $error("chardisp_regif: display bank must hold 128 entries");
   end
   if (CG_AW != 6 || CG_DEPTH != (1 << CG_AW)) begin : g_bad_cg
      $error("chardisp_regif: glyph bank must hold 64 entries");
   end

   bus_cmd_t   cmd;
   logic       stb;
   logic       busy, tmr_last;
   logic       accept;
   bus_op_e    op;
   logic [6:0] ac_q;
   logic       dir_up_q, sel_cg_q, fetch_pend_q;
   logic [7:0] dr_q;
   logic [7:0] dd_rdata, cg_rdata, rd_data;
   logic       dd_we, cg_we;

   cdr_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .cmd_in ('{rs: rs, rw: rw, db: db_in}),
      .stb    (stb),
      .cmd    (cmd)
   );

   assign op     = bus_op_e'({cmd.rs, cmd.rw});
   assign accept = stb && !busy && (op != OP_STATUS);

   cdr_busy_timer #(.CYCLES(BUSY_CYCLES)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .busy  (busy),
      .last  (tmr_last)
   );

   assign dd_we = accept && (op == OP_DWRITE) && !sel_cg_q;
   assign cg_we = accept && (op == OP_DWRITE) &&  sel_cg_q;

   cdr_ram #(.DEPTH(DD_DEPTH), .DW(8)) i_dd_ram (
      .clk   (clk),
      .we    (dd_we),
      .waddr (ac_q),
      .wdata (cmd.db),
      .raddr (ac_q),
      .rdata (dd_rdata)
   );

   cdr_ram #(.DEPTH(CG_DEPTH), .DW(8)) i_cg_ram (
      .clk   (clk),
      .we    (cg_we),
      .waddr (ac_q[CG_AW-1:0]),
      .wdata (cmd.db),
      .raddr (ac_q[CG_AW-1:0]),
      .rdata (cg_rdata)
   );

   assign rd_data = sel_cg_q ? cg_rdata : dd_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q         <= '0;
         dir_up_q     <= 1'b1;
         sel_cg_q     <= 1'b0;
         dr_q         <= '0;
         fetch_pend_q <= 1'b0;
      end else if (accept) begin
         unique case (op)
            OP_INSTR: begin
               if (cmd.db[7]) begin
                  sel_cg_q     <= 1'b0;
                  ac_q         <= cmd.db[6:0];
                  fetch_pend_q <= 1'b1;
               end else if (cmd.db[6]) begin
                  sel_cg_q     <= 1'b1;
                  ac_q         <= {1'b0, cmd.db[5:0]};
                  fetch_pend_q <= 1'b1;
               end else if (cmd.db[5:2] == 4'b0001) begin
                  dir_up_q <= cmd.db[1];
               end
            end
            OP_DWRITE: begin
               dr_q <= cmd.db;
               ac_q <= ac_step(ac_q, dir_up_q, sel_cg_q);
            end
            OP_DREAD: begin
               ac_q         <= ac_step(ac_q, dir_up_q, sel_cg_q);
               fetch_pend_q <= 1'b1;
            end
            default: ;
         endcase
      end else if (fetch_pend_q && tmr_last) begin
         dr_q         <= rd_data;
         fetch_pend_q <= 1'b0;
      end
   end

   assign db_oe  = en & rw;
   assign db_out = rs ? dr_q : {busy, ac_q};

endmodule

// File: rtl/cdr_checker.sv
module cdr_checker #(
   parameter int BUSY_CYCLES = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       db_oe,
   input logic       stb,
   input logic       cmd_rs,
   input logic       cmd_rw,
   input logic       busy,
   input logic [6:0] ac,
   input logic       sel_cg
);

   localparam int CW = $clog2(BUSY_CYCLES + 2);

   logic [CW-1:0] busy_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len_q <= '0;
      else if (busy) busy_len_q <= busy_len_q + 1'b1;
      else           busy_len_q <= '0;
   end

   p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !db_oe);

   p_status_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !cmd_rs && cmd_rw) |=> $stable(ac));

   p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !busy && !(!cmd_rs && cmd_rw)) |=> busy);

   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && busy_len_q != 0) |-> (busy_len_q == CW'(BUSY_CYCLES)));

   p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && busy) |=> $stable(ac));

   p_glyph_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sel_cg |-> !ac[6]);

endmodule

bind chardisp_regif cdr_checker #(.BUSY_CYCLES(BUSY_CYCLES)) i_cdr_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .db_oe  (db_oe),
   .stb    (stb),
   .cmd_rs (cmd.rs),
   .cmd_rw (cmd.rw),
   .busy   (busy),
   .ac     (ac_q),
   .sel_cg (sel_cg_q)
);

// File: tb/test_chardisp_regif.sv
module test_chardisp_regif;

   localparam int BUSY = 4;
   localparam int IDLE = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, rs = 1'b0, rw = 1'b0;
   logic [7:0] din = '0;
   logic [7:0] db_out;
   logic       db_oe;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // reference model
   logic [7:0] m_dd [128];
   logic [7:0] m_cg [64];
   logic [6:0] m_ac = '0;
   logic       m_up = 1'b1;
   logic       m_cg_sel = 1'b0;
   logic [7:0] m_dr = '0;

   always #10 clk = ~clk;

   chardisp_regif #(.BUSY_CYCLES(BUSY)) i_chardisp_regif (
      .clk(clk), .rst_n(rst_n), .en(en), .rs(rs), .rw(rw),
      .db_in(din), .db_out(db_out), .db_oe(db_oe)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] nxt_ac(input logic [6:0] a);
      logic [6:0] n;
      if (m_up) n = (a == 7'd127) ? 7'd0 : a + 7'd1;
      else      n = (a == 7'd0) ? 7'd127 : a - 7'd1;
      if (m_cg_sel) n = n % 7'd64;
      return n;
   endfunction

   function automatic logic [7:0] m_mem(input logic [6:0] a);
      return m_cg_sel ? m_cg[a[5:0]] : m_dd[a];
   endfunction

   task automatic xfer(input logic r_s, input logic r_w, input logic [7:0] d,
                       output logic [7:0] q);
      @(negedge clk);
      rs = r_s; rw = r_w; din = d; en = 1'b1;
      repeat (2) @(negedge clk);
      q = db_out;
      chk("R2 oe while strobe high", {7'd0, db_oe}, {7'd0, r_w});
      en = 1'b0;
      @(negedge clk);
      if (r_w) chk("R2 oe after strobe low", {7'd0, db_oe}, 8'd0);
      repeat (IDLE) @(negedge clk);
   endtask

   task automatic m_instr(input logic [7:0] d);
      if (d[7]) begin
         m_cg_sel = 1'b0; m_ac = d[6:0]; m_dr = m_mem(m_ac);
      end else if (d[6]) begin
         m_cg_sel = 1'b1; m_ac = {1'b0, d[5:0]}; m_dr = m_mem(m_ac);
      end else if (d[7:2] == 6'b000001) begin
         m_up = d[1];
      end
   endtask

   task automatic m_write(input logic [7:0] d);
      if (m_cg_sel) m_cg[m_ac[5:0]] = d; else m_dd[m_ac] = d;
      m_dr = d;
      m_ac = nxt_ac(m_ac);
   endtask

   task automatic do_instr(input logic [7:0] d);
      logic [7:0] q;
      xfer(1'b0, 1'b0, d, q);
      m_instr(d);
   endtask

   task automatic do_write(input logic [7:0] d);
      logic [7:0] q;
      xfer(1'b1, 1'b0, d, q);
      m_write(d);
   endtask

   task automatic do_read(input string tag);
      logic [7:0] q;
      xfer(1'b1, 1'b1, 8'h00, q);
      chk(tag, q, m_dr);
      m_ac = nxt_ac(m_ac);
      m_dr = m_mem(m_ac);
   endtask

   task automatic do_status(input string tag);
      logic [7:0] q;
      xfer(1'b0, 1'b1, 8'h00, q);
      chk(tag, q, {1'b0, m_ac});
   endtask

   // two strobes back to back: the second lands while busy
   task automatic double_strobe(input logic r_s1, input logic [7:0] d1,
                                input logic r_s2, input logic [7:0] d2);
      @(negedge clk);
      rs = r_s1; rw = 1'b0; din = d1; en = 1'b1;
      repeat (2) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      rs = r_s2; din = d2; en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      repeat (IDLE) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      int busy_cnt;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state seen through the status byte and data register
      chk("R2 oe idle after reset", {7'd0, db_oe}, 8'd0);
      do_status("R1 status after reset");
      xfer(1'b1, 1'b1, 8'h00, q);
      chk("R1 data register after reset", q, 8'h00);
      m_ac = 7'd1; // that read stepped the counter upward
      do_status("R1 increment is reset direction");

      // R6, R9, R11: fill display bank, counter wraps to 0
      do_instr(8'h80);
      do_status("R6 display address set");
      for (int i = 0; i < 128; i++) do_write(8'($urandom));
      do_status("R11 display wrap upward");
      // R7, R11: fill glyph bank
      do_instr(8'h40);
      for (int i = 0; i < 64; i++) do_write(8'($urandom));
      do_status("R11 glyph wrap upward");

      // R11 downward wraps
      do_instr(8'h04);                       // R8 decrement
      do_instr(8'h80);
      do_write(8'h3C);
      do_status("R11 display wrap downward");
      do_instr(8'h40);
      do_write(8'hC3);
      do_status("R11 glyph wrap downward");
      do_instr(8'h06);                       // R8 increment
      do_instr(8'h7F);                       // R7 glyph 63
      do_read("R7 glyph fetch");
      do_status("R11 glyph read wrap");

      // R4: count busy clocks on the status byte after an instruction
      @(negedge clk);
      rs = 1'b0; rw = 1'b0; din = 8'h06; en = 1'b1;
      repeat (2) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      rw = 1'b1; en = 1'b1;
      busy_cnt = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (db_out[7]) busy_cnt++;
      end
      en = 1'b0;
      repeat (IDLE) @(negedge clk);
      chk("R4 busy length", 8'(busy_cnt), 8'(BUSY));

      // R5: data write during busy is ignored
      do_instr(8'h90);
      double_strobe(1'b1, 8'h5A, 1'b1, 8'hA5);
      m_write(8'h5A);
      do_status("R5 write during busy ignored (counter)");
      // R5: instruction during busy is ignored
      double_strobe(1'b1, 8'h33, 1'b0, 8'hC0);
      m_write(8'h33);
      do_status("R5 instruction during busy ignored");
      do_instr(8'h90);
      do_read("R5 first write kept");
      do_read("R5 second write kept");
      do_read("R5 neighbour untouched");

      // R12: only the last high cycle's fields count
      @(negedge clk);
      rs = 1'b0; rw = 1'b0; din = 8'hFF; en = 1'b1;
      @(negedge clk);
      din = 8'h85;
      @(negedge clk);
      en = 1'b0;
      repeat (IDLE) @(negedge clk);
      m_instr(8'h85);
      do_status("R12 last-cycle fields used");

      // R8: other instruction bytes change nothing
      do_instr(8'h01);
      do_instr(8'h08);
      do_instr(8'h3F);
      do_status("R8 other instruction no effect");
      do_read("R8 data register kept");

      // constrained random mix
      for (int n = 0; n < 300; n++) begin
         case ($urandom_range(0, 6))
            0: do_instr(8'h80 | 8'($urandom_range(0, 127)));
            1: do_instr(8'h40 | 8'($urandom_range(0, 63)));
            2: do_instr(8'h04 | 8'($urandom_range(0, 3)));
            3: do_write(8'($urandom));
            4: do_read("R10 random data read");
            5: do_status("R3 random status read");
            default: do_instr(8'($urandom_range(0, 3)) | (8'($urandom_range(0, 1)) << 3));
         endcase
      end
      do_status("R3 final status");
      do_read("R10 final read");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule